// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, made of a segment number and an offset, into a physical address. The segment table sits in ordinary memory. A table origin input gives where it starts, and a table length input gives how many segments it holds. A translation starts when the block is idle and a one-cycle start pulse arrives. The block first bounds the segment number against the length. It then reads the two-word table entry over a simple read port and checks the entry's valid and access-right flags. Last, it compares the offset with the segment limit and adds the offset to the segment base.

Each translation ends with a one-cycle completion pulse that carries either a physical address or a trap cause. A caller issues one translation at a time and waits for the pulse. The read port accepts a request in the cycle it is raised. It returns exactly one response after any number of cycles.

Top module: `seg_xlat`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd`, `fault`, `cause` and `phys_addr` are all zero.
- R2: When the segment number is greater than or equal to `tbl_len`, the translation ends with cause 1 and issues no memory read.
- R3: A legal segment number causes exactly two reads. Each read is a one-cycle `mem_rd` pulse. The first read is at `tbl_base + 8*seg` and returns the segment base. The second read is at `tbl_base + 8*seg + 4` and returns the control word.
- R4: A control word with bit 31 (valid) at 0 ends the translation with cause 2.
- R5: Control-word bits 30, 29 and 28 grant read, write and execute. `acc_kind` 0 needs bit 30, 1 needs bit 29 and 2 needs bit 28. `acc_kind` 3 is never permitted. A missing right gives cause 3.
- R6: The limit sits in control-word bits [OFF_W-1:0]. An offset greater than or equal to the limit gives cause 4, so a limit of 0 rejects every offset.
- R7: A translation that passes every check gives cause 0 and `phys_addr` = base + offset, taken modulo 2^32. A trapped translation gives `phys_addr` 0.
- R8: When several checks fail, the reported cause follows the order range, then valid, then rights, then limit.
- R9: A start pulse while `busy` is high is ignored and does not change the result of the translation in flight.
- R10: `done` is high for exactly one cycle per translation, and at that cycle `fault` equals (`cause` != 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Byte address of segment table entry 0 |
| tbl_len | input | SEG_W+1 | Number of segments in the table |
| start | input | 1 | Begin a translation (taken only when idle) |
| seg_num | input | SEG_W | Segment number of the logical address |
| offset | input | OFF_W | Offset of the logical address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A translation is in flight or completing |
| mem_rd | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Byte address of the table read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation trapped |
| cause | output | 3 | 0 none, 1 range, 2 invalid, 3 protection, 4 limit |
| phys_addr | output | 32 | Translated physical address |

## Verification
The hardest case to reach from the ports is a collision of faults where the priority order decides the result. One example is an entry that is invalid, grants no rights and has a limit below the offset. Another is a start pulse that lands while the two table reads are still waiting on a slow response. The bench fills the table with random bases, flags and small limits, and draws offsets from a range that straddles the limits. It adds a random response delay of zero to two cycles. Directed cases then place offsets at limit-1 and at limit, use a zero limit, force base-plus-offset wraparound, set the table length to zero, and pulse start again during an active translation.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RANGE   = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_PROT    = 3'd3,
        CAUSE_LIMIT   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2,
        ST_RESP = 2'd3
    } state_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // flag positions inside the entry control word
    localparam int FLAG_VALID = 31;
    localparam int FLAG_RD    = 30;
    localparam int FLAG_WR    = 29;
    localparam int FLAG_EX    = 28;

endpackage

// File: rtl/seg_entry_chk.sv
module seg_entry_chk
    import seg_xlat_pkg::*;
#(
    parameter int OFF_W = 24
) (
    input  logic [3:0]       flags,
    input  logic [OFF_W-1:0] limit,
    input  logic [1:0]       acc,
    input  logic [OFF_W-1:0] off,
    output cause_e           cause
);
    // flags = control word bits [31:28]
    localparam int F_V = FLAG_VALID - 28;
    localparam int F_R = FLAG_RD - 28;
    localparam int F_W = FLAG_WR - 28;
    localparam int F_X = FLAG_EX - 28;

    logic allowed;

    always_comb begin
        case (acc)
            ACC_READ:  allowed = flags[F_R];
            ACC_WRITE: allowed = flags[F_W];
            ACC_EXEC:  allowed = flags[F_X];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!flags[F_V])         cause = CAUSE_INVALID;
        else if (!allowed)       cause = CAUSE_PROT;
        else if (off >= limit)   cause = CAUSE_LIMIT;
        else                     cause = CAUSE_NONE;
    end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
    parameter int SEG_W = 6,
    parameter int OFF_W = 24
) (
    input  logic [31:0]      tbl_base,
    input  logic [SEG_W-1:0] seg,
    input  logic [31:0]      seg_base,
    input  logic [OFF_W-1:0] off,
    output logic [31:0]      entry_addr,
    output logic [31:0]      phys
);
    localparam int ENT_SHIFT = 3;               // two 32-bit words per entry
    localparam int PAD_SEG   = 32 - SEG_W - ENT_SHIFT;
    localparam int PAD_OFF   = 32 - OFF_W;

    assign entry_addr = tbl_base + {{PAD_SEG{1'b0}}, seg, {ENT_SHIFT{1'b0}}};
    assign phys       = seg_base + {{PAD_OFF{1'b0}}, off};

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 6,
    parameter int OFF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      tbl_base,
    input  logic [SEG_W:0]   tbl_len,
    input  logic             start,
    input  logic [SEG_W-1:0] seg_num,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       acc_kind,
    output logic             busy,
    output logic             mem_rd,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [2:0]       cause,
    output logic [31:0]      phys_addr
);
    localparam logic [31:0] WORD_STEP = 32'd4;

    typedef struct packed {
        state_e           st;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic [1:0]       acc;
        logic [31:0]      base;
        logic             rd;
        logic [31:0]      rd_addr;
        logic             done;
        cause_e           cause;
        logic [31:0]      phys;
    } regs_t;

    regs_t q, d;

    logic [31:0] entry_addr;
    logic [31:0] phys_sum;
    cause_e      entry_cause;
    logic        range_bad;

    seg_addr_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_addr (
        .tbl_base   (tbl_base),
        .seg        (seg_num),
        .seg_base   (q.base),
        .off        (q.off),
        .entry_addr (entry_addr),
        .phys       (phys_sum)
    );

    seg_entry_chk #(.OFF_W(OFF_W)) u_chk (
        .flags (mem_rdata[31:28]),
        .limit (mem_rdata[OFF_W-1:0]),
        .acc   (q.acc),
        .off   (q.off),
        .cause (entry_cause)
    );

    assign range_bad = ({1'b0, seg_num} >= tbl_len);

    always_comb begin
        d      = q;
        d.rd   = 1'b0;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.seg = seg_num;
                    d.off = offset;
                    d.acc = acc_kind;
                    if (range_bad) begin
                        d.cause = CAUSE_RANGE;
                        d.phys  = '0;
                        d.done  = 1'b1;
                        d.st    = ST_RESP;
                    end else begin
                        d.rd      = 1'b1;
                        d.rd_addr = entry_addr;
                        d.st      = ST_RD0;
                    end
                end
            end
            ST_RD0: begin
                if (mem_rvalid) begin
                    d.base    = mem_rdata;
                    d.rd      = 1'b1;
                    d.rd_addr = q.rd_addr + WORD_STEP;
                    d.st      = ST_RD1;
                end
            end
            ST_RD1: begin
                if (mem_rvalid) begin
                    d.cause = entry_cause;
                    d.phys  = (entry_cause == CAUSE_NONE) ? phys_sum : '0;
                    d.done  = 1'b1;
                    d.st    = ST_RESP;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign mem_rd    = q.rd;
    assign mem_addr  = q.rd_addr;
    assign done      = q.done;
    assign cause     = q.cause;
    assign fault     = (q.cause != CAUSE_NONE);
    assign phys_addr = q.phys;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int SEG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEG_W:0]   tbl_len,
    input logic             start,
    input logic [SEG_W-1:0] seg_num,
    input logic             busy,
    input logic             mem_rd,
    input logic             done,
    input logic             fault,
    input logic [2:0]       cause
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (cause != 3'd0)));

    // R2
    range_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ({1'b0, seg_num} >= tbl_len)) |=> (done && cause == 3'd1 && !mem_rd));

    // R3
    rd_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind seg_xlat seg_xlat_chk #(.SEG_W(SEG_W)) u_seg_xlat_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tbl_len (tbl_len),
    .start   (start),
    .seg_num (seg_num),
    .busy    (busy),
    .mem_rd  (mem_rd),
    .done    (done),
    .fault   (fault),
    .cause   (cause)
);

// File: tb/seg_xlat_bench.sv
`timescale 1ns/1ps
module seg_xlat_bench;
    localparam int SEG_W = 6;
    localparam int OFF_W = 24;
    localparam int NSEG  = 1 << SEG_W;
    localparam logic [31:0] TBASE = 32'h0000_4000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      tbl_base = TBASE;
    logic [SEG_W:0]   tbl_len = '0;
    logic             start = 1'b0;
    logic [SEG_W-1:0] seg_num = '0;
    logic [OFF_W-1:0] offset = '0;
    logic [1:0]       acc_kind = '0;
    logic             busy, mem_rd, done, fault;
    logic [31:0]      mem_addr, phys_addr;
    logic             mem_rvalid = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic [2:0]       cause;

    int total = 0;
    int bad = 0;

    logic [31:0] tbl [0:2*NSEG-1];

    // memory model state
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          pend_wait = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [0:1];
    int          max_lat = 3;

    always #2 clk = ~clk;

    seg_xlat #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_seg_xlat (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .start(start), .seg_num(seg_num), .offset(offset), .acc_kind(acc_kind),
        .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .cause(cause), .phys_addr(phys_addr)
    );

    function automatic logic [31:0] mem_word(logic [31:0] a);
        logic [31:0] idx;
        idx = (a - TBASE) >> 2;
        return tbl[idx[SEG_W:0]];
    endfunction

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            if (pend_wait == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(pend_addr);
                pend = 1'b0;
            end else begin
                pend_wait = pend_wait - 1;
            end
        end
        if (mem_rd) begin
            pend      = 1'b1;
            pend_addr = mem_addr;
            pend_wait = $urandom % max_lat;
            rd_log[rd_cnt % 2] = mem_addr;
            rd_cnt    = rd_cnt + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cause(int s, logic [OFF_W-1:0] off, logic [1:0] acc);
        logic [31:0] w1;
        logic ok;
        w1 = tbl[2*s+1];
        if (s >= int'(tbl_len)) return 3'd1;
        if (!w1[31]) return 3'd2;
        case (acc)
            2'd0: ok = w1[30];
            2'd1: ok = w1[29];
            2'd2: ok = w1[28];
            default: ok = 1'b0;
        endcase
        if (!ok) return 3'd3;
        if (off >= w1[OFF_W-1:0]) return 3'd4;
        return 3'd0;
    endfunction

    // one translation; intrude = pulse start again while busy (R9)
    task automatic txn(int s, logic [OFF_W-1:0] off, logic [1:0] acc, bit intrude, string tag);
        logic [2:0]  ec;
        logic [31:0] ep;
        int  rc0, n;
        bit  got;
        ec  = exp_cause(s, off, acc);
        ep  = (ec == 3'd0) ? tbl[2*s] + {8'd0, off} : 32'd0;
        rc0 = rd_cnt;
        @(negedge clk);
        seg_num = SEG_W'(s); offset = off; acc_kind = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = done;
        if (intrude) begin
            seg_num = ~SEG_W'(s); offset = off + 24'd1; acc_kind = ~acc; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            got = got || done;
            n = 1;
        end else n = 0;
        while (!got && n < 60) begin
            @(negedge clk);
            got = done;
            n++;
        end
        if (!got) begin
            check({tag, " R10 done timeout"}, 32'd0, 32'd1);
            return;
        end
        check({tag, " R8 cause"}, {29'd0, cause}, {29'd0, ec});
        check({tag, " R10 fault"}, {31'd0, fault}, {31'd0, ec != 3'd0});
        check({tag, " R7 phys"}, phys_addr, ep);
        if (ec == 3'd1) begin
            check({tag, " R2 no reads"}, rd_cnt - rc0, 0);
        end else begin
            check({tag, " R3 read count"}, rd_cnt - rc0, 2);
            check({tag, " R3 first addr"}, rd_log[rc0 % 2], TBASE + 32'(s) * 8);
            check({tag, " R3 second addr"}, rd_log[(rc0 + 1) % 2], TBASE + 32'(s) * 8 + 4);
        end
        @(negedge clk);
        check({tag, " R10 single pulse"}, {31'd0, done}, 32'd0);
        if (intrude) begin
            repeat (3) @(negedge clk);
            check({tag, " R9 no second run"}, {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSEG; i++) begin
            tbl[2*i]   = $urandom;
            tbl[2*i+1] = {($urandom % 8) != 0, 3'($urandom), 4'd0, 24'($urandom % 4096)};
        end
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 done", {31'd0, done}, 0);
        check("R1 mem_rd", {31'd0, mem_rd}, 0);
        check("R1 fault", {31'd0, fault}, 0);
        check("R1 cause", {29'd0, cause}, 0);
        check("R1 phys", phys_addr, 0);
        rst_n = 1'b1;

        // R2: empty table, every segment out of range
        tbl_len = '0;
        txn(0, 24'd5, 2'd0, 1'b0, "len0");
        tbl_len = 7'd10;
        txn(10, 24'd0, 2'd0, 1'b0, "seg=len");

        // directed entries
        tbl[0] = 32'h1000_0000; tbl[1] = {1'b1, 3'b111, 4'd0, 24'd100};
        txn(0, 24'd99, 2'd0, 1'b0, "R6 limit-1");
        txn(0, 24'd100, 2'd1, 1'b0, "R6 at limit");
        txn(0, 24'd0, 2'd3, 1'b0, "R5 acc3");
        tbl[2] = 32'hFFFF_FFF0; tbl[3] = {1'b1, 3'b001, 4'd0, 24'h00_1000};
        txn(1, 24'h20, 2'd2, 1'b0, "R7 wrap");
        txn(1, 24'h20, 2'd0, 1'b0, "R5 no read");
        tbl[4] = 32'h0000_2000; tbl[5] = {1'b1, 3'b111, 4'd0, 24'd0};
        txn(2, 24'd0, 2'd0, 1'b0, "R6 zero limit");
        tbl[6] = 32'h0000_3000; tbl[7] = {1'b0, 3'b000, 4'd0, 24'd0};
        txn(3, 24'd50, 2'd0, 1'b0, "R4 R8 invalid first");
        tbl[8] = 32'h0000_5000; tbl[9] = {1'b1, 3'b000, 4'd0, 24'd1};
        txn(4, 24'd50, 2'd1, 1'b0, "R8 prot before limit");
        txn(9, 24'd10, 2'd0, 1'b0, "seg=len-1");

        // R9: start while busy is ignored
        txn(0, 24'd7, 2'd0, 1'b1, "R9 during reads");
        txn(12, 24'd7, 2'd0, 1'b1, "R9 during range trap");

        // random phase
        tbl_len = 7'd48;
        for (int k = 0; k < 250; k++) begin
            txn(int'($urandom % NSEG), 24'($urandom % 5000), 2'($urandom),
                ($urandom % 8) == 0, "rand");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule